// File: doc/BRIEF.md
# Audio Mute and Play Controller

This block sits between a buffer of decoded stereo samples and the serial PCM output stage. It merges an active-low mute pin with a mute control bit, and an active-low play pin with a play control bit. The result is one of four output modes:

- **Stopped:** the output clocks halt.
- **Held mute:** the clocks run and the data is forced to zero.
- **Playing:** samples pass through unchanged.
- **Soft mute:** samples keep being consumed while their amplitude is shifted down frame by frame.

A new mode takes effect only on a left/right frame boundary, so a channel pair is never split. The serializer signals each boundary with a one-cycle strobe. While the clocks are stopped, no such strobe arrives, and a new mode is applied on the next clock.

Each boundary in a consuming mode takes one stereo word from the upstream valid/ready stream and registers it as the word for the coming frame. In the two non-play modes no word is taken, so playback later resumes with exactly the next word in order. A request flag tells the upstream source to stop sending when the sample buffer reports full. The flag is forced high during reset.

Top module: `av_mute_play_ctrl`

## Requirements
- R1: Effective mute is true when `mute_pin_n` is 0 or `mute_reg` is 1. Effective play is true only when `play_pin_n` is 0 and `play_reg` is 1. The pair {play, mute} selects the mode: 00 stopped, 01 held mute, 10 playing, 11 soft mute.
- R2: A boundary is a cycle in which `frame_end_i` is 1, or in which the controller is stopped. The mode, `clk_run_o` and `out_data_o` change only at the clock edge ending a boundary cycle.
- R3: In the stopped mode, `clk_run_o` is 0, `out_data_o` keeps its last value, and no input word is taken.
- R4: In the held-mute mode, `clk_run_o` is 1 and `out_data_o` is zero from the first boundary on. No input word is taken.
- R5: In the playing mode, `in_ready_o` is 1 exactly in boundary cycles. If `in_valid_i` is 1 there, the next `out_data_o` equals `in_data_i`; otherwise it is zero.
- R6: In both non-play modes `in_ready_o` stays 0. When play returns, the first word output is the oldest word not yet taken.
- R7: In soft mute, each boundary takes a word. At the k-th consecutive soft-mute boundary, each 16-bit channel of that word is arithmetically right-shifted by k. From k = 16 on, the output is zero.
- R8: At the first boundary outside soft mute, the shift count returns to zero, so a playing boundary outputs the word at full gain.
- R9: `req_o` is 1 during reset. After reset, it equals `buf_full_i` as sampled at the previous clock edge.
- R10: During reset, `clk_run_o` is 0 and `out_data_o` is 0. After reset the controller is stopped until mute or play becomes effective.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_pin_n | input | 1 | Mute pin, active low |
| mute_reg | input | 1 | Mute control bit, active high |
| play_pin_n | input | 1 | Play pin, active low |
| play_reg | input | 1 | Play control bit, active high |
| frame_end_i | input | 1 | One-cycle strobe from the serializer at the end of each left/right frame |
| buf_full_i | input | 1 | Sample buffer full indication |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word taken this cycle |
| in_data_i | input | SW*CHANNELS | Stereo input word, channel 0 in the low bits |
| clk_run_o | output | 1 | Output clocks enabled |
| out_data_o | output | SW*CHANNELS | Word presented to the serializer for the current frame |
| req_o | output | 1 | Request flag: high means stop sending data |

## Verification
A wrong mode register shows up within one frame, at the first edge after a boundary. It appears as a wrong `clk_run_o` level, a zero word where a sample was due, or `in_ready_o` asserting when it should not. A wrong shift count shows up as a word with the wrong scaling at the next soft-mute or playing boundary. A word dropped or repeated during a pause is not visible while paused; it appears at the first playing boundary, as an out-of-order output word. For that reason the stimulus pauses and resumes many times against a running word sequence.

// File: rtl/av_mute_play_ctrl.sv
module av_mute_play_ctrl #(
  parameter int SW         = 16,
  parameter int CHANNELS   = 2,
  parameter int RAMP_STEPS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mute_pin_n,
  input  logic                   mute_reg,
  input  logic                   play_pin_n,
  input  logic                   play_reg,
  input  logic                   frame_end_i,
  input  logic                   buf_full_i,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [SW*CHANNELS-1:0] in_data_i,
  output logic                   clk_run_o,
  output logic [SW*CHANNELS-1:0] out_data_o,
  output logic                   req_o
);
  localparam int DW  = SW * CHANNELS;
  localparam int SHW = $clog2(RAMP_STEPS + 1);
  localparam logic [SHW-1:0] STEP_MAX = SHW'(RAMP_STEPS);

  localparam logic [1:0] M_STOP = 2'b00;
  localparam logic [1:0] M_HOLD = 2'b01;
  localparam logic [1:0] M_PLAY = 2'b10;
  localparam logic [1:0] M_SOFT = 2'b11;

  logic [1:0]     mode_q, mode_nx;
  logic [SHW-1:0] shift_q, shift_nx;
  logic [DW-1:0]  scaled;
  logic           running, boundary;

  assign mode_nx  = {~play_pin_n & play_reg, ~mute_pin_n | mute_reg};
  assign running  = (mode_q != M_STOP);
  assign boundary = frame_end_i | ~running;

  assign in_ready_o = boundary & mode_nx[1];
  assign clk_run_o  = running;

  assign shift_nx = (mode_nx != M_SOFT) ? '0 :
                    (shift_q == STEP_MAX) ? STEP_MAX : shift_q + SHW'(1);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    assign scaled[c*SW +: SW] = (shift_nx == STEP_MAX) ? '0 :
                                SW'($signed(in_data_i[c*SW +: SW]) >>> shift_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_STOP;
      shift_q    <= '0;
      out_data_o <= '0;
      req_o      <= 1'b1;
    end else begin
      req_o <= buf_full_i;
      if (boundary) begin
        mode_q  <= mode_nx;
        shift_q <= shift_nx;
        case (mode_nx)
          M_HOLD:         out_data_o <= '0;
          M_PLAY, M_SOFT: out_data_o <= in_valid_i ? scaled : '0;
          default:        out_data_o <= out_data_o;
        endcase
      end
    end
  end
endmodule

// File: rtl/av_mute_play_ctrl_chk.sv
module av_mute_play_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_end_i,
  input logic          buf_full_i,
  input logic          in_ready_o,
  input logic          clk_run_o,
  input logic          req_o,
  input logic [DW-1:0] out_data_o
);
  AST_REQ_TRACKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> req_o == $past(buf_full_i)); // R9

  AST_CHANGE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clk_run_o) && !$past(frame_end_i))
      |-> ($stable(clk_run_o) && $stable(out_data_o))); // R2

  AST_STOPPED_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clk_run_o) && !clk_run_o) |-> $stable(out_data_o)); // R3

  AST_READY_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> (frame_end_i || !clk_run_o)); // R5
endmodule

bind av_mute_play_ctrl av_mute_play_ctrl_chk #(.DW(SW*CHANNELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end_i), .buf_full_i(buf_full_i),
  .in_ready_o(in_ready_o), .clk_run_o(clk_run_o), .req_o(req_o),
  .out_data_o(out_data_o));

// File: tb/av_mute_play_ctrl_tb.sv
module av_mute_play_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int SW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mute_pin_n = 1'b1, mute_reg = 1'b0, play_pin_n = 1'b1, play_reg = 1'b0;
  logic frame_end_i = 1'b0, buf_full_i = 1'b0, in_valid_i = 1'b0;
  logic in_ready_o, clk_run_o, req_o;
  logic [31:0] in_data_i, out_data_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [1:0]  m_mode = 2'b00;
  int          m_shift = 0;
  logic [31:0] m_out = '0;
  logic        m_req = 1'b1;
  logic [31:0] word;

  always #(PERIOD/2) clk = ~clk;

  av_mute_play_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mute_pin_n(mute_pin_n), .mute_reg(mute_reg),
    .play_pin_n(play_pin_n), .play_reg(play_reg), .frame_end_i(frame_end_i),
    .buf_full_i(buf_full_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .clk_run_o(clk_run_o), .out_data_o(out_data_o), .req_o(req_o));

  function automatic logic [31:0] scale(input logic [31:0] w, input int k);
    logic [31:0] r;
    for (int c = 0; c < 2; c++)
      r[c*SW +: SW] = (k >= 16) ? 16'h0 : 16'($signed(w[c*SW +: SW]) >>> k);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic mp_n, input logic mr, input logic pp_n, input logic pr,
                      input logic fe, input logic bf, input logic iv, input string tag);
    logic [1:0] nm;
    logic bnd, rdy;
    string ot;
    @(negedge clk);
    mute_pin_n = mp_n; mute_reg = mr; play_pin_n = pp_n; play_reg = pr;
    frame_end_i = fe; buf_full_i = bf; in_valid_i = iv; in_data_i = word;
    #1;
    nm  = {~pp_n & pr, ~mp_n | mr};
    bnd = fe | (m_mode == 2'b00);
    rdy = bnd & nm[1];
    check(nm[1] ? "R5" : "R6", {31'b0, in_ready_o}, {31'b0, rdy});
    if (bnd) begin
      m_mode = nm;
      m_shift = (nm == 2'b11) ? ((m_shift >= 16) ? 16 : m_shift + 1) : 0;
      case (nm)
        2'b01:   m_out = '0;
        2'b10:   m_out = iv ? word : '0;
        2'b11:   m_out = iv ? scale(word, m_shift) : '0;
        default: m_out = m_out;
      endcase
    end
    m_req = bf;
    @(posedge clk);
    #1;
    case (m_mode)
      2'b00:   ot = "R3";
      2'b01:   ot = "R4";
      2'b10:   ot = "R5";
      default: ot = "R7";
    endcase
    if (tag != "") ot = tag;
    check(ot, out_data_o, m_out);
    check((tag != "") ? tag : "R2", {31'b0, clk_run_o}, {31'b0, m_mode != 2'b00});
    check("R9", {31'b0, req_o}, {31'b0, m_req});
    if (rdy && iv) word = $urandom;
  endtask

  initial begin
    void'($urandom(32'd1234));
    word = $urandom;
    in_data_i = word;
    // reset state
    repeat (3) @(posedge clk);
    #1;
    check("R10", out_data_o, 32'h0);
    check("R10", {31'b0, clk_run_o}, 32'h0);
    check("R9", {31'b0, req_o}, 32'h1);
    @(negedge clk); rst_n = 1'b1;
    // stays stopped with neither mode effective; request follows buffer
    repeat (3) step(1, 0, 1, 0, 0, 0, 1, "R10");
    step(1, 0, 1, 0, 0, 1, 1, "");
    // decode of all pin/bit combinations from the stopped state
    for (int i = 0; i < 16; i++) begin
      step(i[0], i[1], i[2], i[3], 0, 0, 1, "R1");
      step(1, 0, 1, 0, 1, 0, 1, "R1");
    end
    // soft ramp on a fixed word: 20 frames, then full gain restored
    step(1, 0, 0, 1, 1, 0, 1, "");
    word = 32'h8000_7FFF;
    for (int k = 1; k <= 20; k++) begin
      step(0, 0, 0, 1, 1, 0, 1, "R7");
      word = 32'h8000_7FFF;
    end
    check("R7", out_data_o, 32'h0);
    step(1, 0, 0, 1, 1, 0, 1, "R8");
    check("R8", out_data_o, 32'h8000_7FFF);
    // pause in held mute and stop, then resume in order
    for (int r = 0; r < 4; r++) begin
      step(0, 0, 1, 0, 1, 1, 1, "R4");
      step(1, 0, 1, 0, 1, 1, 1, "R3");
      step(1, 0, 1, 0, 0, 1, 1, "R3");
      step(1, 0, 0, 1, 1, 0, 1, "R6");
      step(1, 0, 0, 1, 0, 0, 1, "R2");
    end
    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] p;
      p = 4'($urandom);
      if ($urandom % 3 != 0) p = 4'b1001 ^ {3'b0, p[0] & p[1]};
      step(p[0], p[1], p[2], p[3], ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 8) != 0, "");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule